// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Front End

This block is the clocked front end of a 64-bit-wide synchronous static RAM with a small internal array. On each rising clock edge it samples the address, three chip selects, two address strobes, the burst advance input and the write controls. It then decides whether the edge starts a read, starts a write, continues a burst or deselects the device. A 2-bit burst counter produces the following addresses in either linear or interleaved order. Writes are split into eight byte lanes. A global write input overrides the per-lane selects. Read data is registered and released through an output enable that acts without waiting for the clock.

A sleep request puts the device into power-down, and the stored words are kept. After the request is released, the block stays in a recovery window. Address strobes during that window are dropped and reported on a violation flag. The controller is a four-state machine:

- `ST_DESEL`: nothing selected.
- `ST_ACTIVE`: a burst is open.
- `ST_SLEEP`: power-down.
- `ST_WAKE`: recovery window.

The transitions are these:

- DESEL or ACTIVE go to SLEEP when the sleep request is high.
- DESEL or ACTIVE go to ACTIVE on a strobe with every select active.
- DESEL or ACTIVE go to DESEL on a strobe with a secondary select inactive.
- SLEEP goes to WAKE when the request drops.
- WAKE goes back to SLEEP if the request rises again.
- WAKE goes to DESEL once the recovery count expires.
- Without any of these events the state holds.

Top module: `sbsram_front`

## Requirements
- R1: After reset `rdata_vld` is low, `rdata` is zero, `pwr_down` and `wake_viol` are low, and the device is deselected.
- R2: A low `proc_strb_n` with `sel_main_n` low, `sel_aux` high and `sel_aux_n` low always starts a read of `addr`, even when the write controls are asserted on that edge. The word appears on `rdata` with `rdata_vld` high after that edge.
- R3: A low `ctl_strb_n` with all selects active writes `wdata` at that same edge when a write is requested. With no write request it starts a read instead. During a write beat `rdata_vld` is low.
- R4: Lane n (bits 8n+7..8n) is written when `lane_wr_en_n` and `lane_sel_n[n]` are both low. The other lanes keep their contents. When `lane_wr_en_n` is high, `lane_sel_n` has no effect.
- R5: A low `all_wr_n` writes all eight lanes, whatever `lane_wr_en_n` and `lane_sel_n` are.
- R6: After a processor-strobe read, a write request on the next edge with `burst_adv_n` high writes `wdata` to the accepted address.
- R7: While `sel_main_n` is high, `proc_strb_n` is ignored. No address is loaded, and an open burst carries on as if no strobe had been given.
- R8: `sel_aux` and `sel_aux_n` are sampled only on strobe edges. If `sel_aux` is low or `sel_aux_n` is high on a strobe edge, the device deselects: `rdata_vld` stays low and later edges perform no access until the next accepted strobe. Changing these selects between strobes has no effect.
- R9: `burst_adv_n` low on a continuation edge steps a 2-bit count, and the upper address bits stay fixed. With `linear_mode` at 1 the low bits are start+count mod 4. With `linear_mode` at 0 they are start XOR count. `burst_adv_n` high repeats the current address as a wait state.
- R10: `out_en_n` high forces `rdata_vld` low and `rdata` to zero at once, without waiting for a clock edge. The burst is not disturbed, and the data returns when `out_en_n` falls.
- R11: `sleep_req` high at an edge enters power-down. `pwr_down` goes high, reads and writes are refused, and the array contents are kept.
- R12: After the edge that first sees `sleep_req` low, the next RECOV (default 2) edges ignore strobes. Each ignored strobe raises `wake_viol` for one cycle. A strobe on the following edge is accepted, and the device starts that edge deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Word address |
| sel_main_n | input | 1 | Primary select, active low; also gates the processor strobe |
| sel_aux | input | 1 | Secondary select, active high |
| sel_aux_n | input | 1 | Secondary select, active low |
| proc_strb_n | input | 1 | Processor address strobe, always starts a read |
| ctl_strb_n | input | 1 | Controller address strobe, read or write |
| burst_adv_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Global write, all lanes |
| lane_wr_en_n | input | 1 | Qualifier for per-lane writes |
| lane_sel_n | input | LANES | Per-lane write selects |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Power-down request, active high |
| linear_mode | input | 1 | 1 = linear burst order, 0 = interleaved |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_vld | output | 1 | Read data is being driven |
| pwr_down | output | 1 | Device is in power-down |
| wake_viol | output | 1 | A strobe was dropped in the recovery window |

## Verification
On every cycle, the assertions check these properties:

- A qualified processor strobe is followed by read data.
- A blocked processor strobe leaves a deselected device deselected.
- A strobe with a secondary select inactive always deselects.
- Power-down never shows read data.
- A strobe in the recovery window is flagged and not served.

Only the bench scenarios can show the data-dependent outcomes. These are the lane merging, the global write override, the linear and interleaved address orders, wait states, the write that follows a processor-strobe read, retention through sleep, and the asynchronous output enable.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic [1:0] {
        ST_DESEL  = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_SLEEP  = 2'd2,
        ST_WAKE   = 2'd3
    } sbs_state_e;

    // Low two address bits for a burst beat: linear adds, interleaved XORs
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] cnt,
                                             input logic       lin);
        return lin ? 2'(start + cnt) : (start ^ cnt);
    endfunction

endpackage

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic              lin,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] eff_addr
);

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic [1:0]        cnt_use;

    assign cnt_use  = adv ? 2'(cnt_q + 2'd1) : cnt_q;
    assign eff_addr = load ? addr_in
                           : {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_use, lin)};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= addr_in;
            cnt_q  <= '0;
        end else if (adv) begin
            cnt_q  <= cnt_use;
        end
    end

endmodule

// File: rtl/sbs_lane_dec.sv
module sbs_lane_dec #(
    parameter int LANES = 8
) (
    input  logic             all_wr_n,
    input  logic             lane_wr_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    output logic [LANES-1:0] lane_we,
    output logic             wr_req
);

    always_comb begin
        if (!all_wr_n)
            lane_we = '1;
        else if (!lane_wr_en_n)
            lane_we = ~lane_sel_n;
        else
            lane_we = '0;
    end

    assign wr_req = |lane_we;

endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 8,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] q;

        always_ff @(posedge clk) begin
            if (we[g])
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
            if (rd_en)
                q <= mem[addr];
        end

        assign rdata[g*LANE_W +: LANE_W] = q;
    end

endmodule

// File: rtl/sbsram_front.sv
module sbsram_front
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 8,
    parameter int LANE_W = 8,
    parameter int RECOV  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    sel_main_n,
    input  logic                    sel_aux,
    input  logic                    sel_aux_n,
    input  logic                    proc_strb_n,
    input  logic                    ctl_strb_n,
    input  logic                    burst_adv_n,
    input  logic                    all_wr_n,
    input  logic                    lane_wr_en_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic                    out_en_n,
    input  logic                    sleep_req,
    input  logic                    linear_mode,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_vld,
    output logic                    pwr_down,
    output logic                    wake_viol
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int WCW    = (RECOV > 1) ? $clog2(RECOV) : 1;

    sbs_state_e        state, nxt;
    logic [WCW-1:0]    wcnt;
    logic              rd_vld_q, viol_q;
    logic              strb_p, strb_c, strobe, sel_ok, live;
    logic              load, beat, adv, do_write, do_read, wr_req;
    logic [LANES-1:0]  lane_we, arr_we;
    logic [ADDR_W-1:0] eff_addr;
    logic [DATA_W-1:0] arr_q;

    assign strb_p = ~proc_strb_n & ~sel_main_n;
    assign strb_c = ~ctl_strb_n;
    assign strobe = strb_p | strb_c;
    assign sel_ok = ~sel_main_n & sel_aux & ~sel_aux_n;
    assign live   = ((state == ST_DESEL) || (state == ST_ACTIVE)) && !sleep_req;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_DESEL;
        else
            state <= nxt;
    end

    // Next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_DESEL, ST_ACTIVE: begin
                if (sleep_req)   nxt = ST_SLEEP;
                else if (strobe) nxt = sel_ok ? ST_ACTIVE : ST_DESEL;
            end
            ST_SLEEP: begin
                if (!sleep_req)  nxt = ST_WAKE;
            end
            ST_WAKE: begin
                if (sleep_req)      nxt = ST_SLEEP;
                else if (wcnt == 0) nxt = ST_DESEL;
            end
            default: nxt = ST_DESEL;
        endcase
    end

    // Action decode for this edge
    always_comb begin
        load     = live & strobe & sel_ok;
        beat     = live & (state == ST_ACTIVE) & ~strobe;
        adv      = beat & ~burst_adv_n;
        do_write = ((load & ~strb_p) | beat) & wr_req;
        do_read  = (load | beat) & ~do_write;
        arr_we   = lane_we & {LANES{do_write}};
        pwr_down = (state == ST_SLEEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt     <= '0;
            rd_vld_q <= 1'b0;
            viol_q   <= 1'b0;
        end else begin
            rd_vld_q <= do_read;
            viol_q   <= (state == ST_WAKE) & strobe;
            if (state == ST_SLEEP && !sleep_req)
                wcnt <= WCW'(RECOV - 1);
            else if (state == ST_WAKE && wcnt != 0)
                wcnt <= wcnt - 1'b1;
        end
    end

    sbs_lane_dec #(.LANES(LANES)) u_dec (
        .all_wr_n     (all_wr_n),
        .lane_wr_en_n (lane_wr_en_n),
        .lane_sel_n   (lane_sel_n),
        .lane_we      (lane_we),
        .wr_req       (wr_req)
    );

    sbs_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv      (adv),
        .lin      (linear_mode),
        .addr_in  (addr),
        .eff_addr (eff_addr)
    );

    sbs_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk   (clk),
        .we    (arr_we),
        .rd_en (do_read),
        .addr  (eff_addr),
        .wdata (wdata),
        .rdata (arr_q)
    );

    assign rdata_vld = rd_vld_q & ~out_en_n;
    assign rdata     = rdata_vld ? arr_q : '0;
    assign wake_viol = viol_q;

    // Assertions
    AST_PROC_STRB_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !proc_strb_n && !sel_main_n && sel_aux && !sel_aux_n) |=> rd_vld_q); // R2
    AST_MAIN_SEL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DESEL && sel_main_n && ctl_strb_n && !sleep_req) |=> (state == ST_DESEL && !rd_vld_q)); // R7
    AST_AUX_SEL_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (live && strobe && !(sel_aux && !sel_aux_n)) |=> (state == ST_DESEL && !rd_vld_q)); // R8
    AST_SLEEP_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP) |-> !rd_vld_q); // R11
    AST_WAKE_STRB_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE && strobe) |=> (wake_viol && !rd_vld_q)); // R12

endmodule

// File: tb/sbsram_front_tb.sv
`timescale 1ns/1ps
module sbsram_front_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        sel_main_n = 1'b0, sel_aux = 1'b1, sel_aux_n = 1'b0;
    logic        proc_strb_n = 1'b1, ctl_strb_n = 1'b1, burst_adv_n = 1'b1;
    logic        all_wr_n = 1'b1, lane_wr_en_n = 1'b1;
    logic [7:0]  lane_sel_n = 8'hFF;
    logic        out_en_n = 1'b0, sleep_req = 1'b0, linear_mode = 1'b1;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        rdata_vld, pwr_down, wake_viol;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] mdl [64];

    always #10 clk = ~clk;

    sbsram_front u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel_main_n(sel_main_n),
        .sel_aux(sel_aux), .sel_aux_n(sel_aux_n), .proc_strb_n(proc_strb_n),
        .ctl_strb_n(ctl_strb_n), .burst_adv_n(burst_adv_n), .all_wr_n(all_wr_n),
        .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n), .out_en_n(out_en_n),
        .sleep_req(sleep_req), .linear_mode(linear_mode), .wdata(wdata),
        .rdata(rdata), .rdata_vld(rdata_vld), .pwr_down(pwr_down), .wake_viol(wake_viol)
    );

    // op(2) addr(6) all_wr_n lane_wr_en_n lane_sel_n(8) linear_mode
    // op 0: controller strobe access, 1: processor strobe read, 2: 4-beat burst read
    localparam int NV = 21;
    localparam logic [18:0] VEC [NV] = '{
        {2'd0, 6'd0,  1'b0, 1'b1, 8'hFF, 1'b1},
        {2'd0, 6'd1,  1'b0, 1'b1, 8'hFF, 1'b1},
        {2'd0, 6'd2,  1'b0, 1'b1, 8'hFF, 1'b1},
        {2'd0, 6'd3,  1'b0, 1'b1, 8'hFF, 1'b1},
        {2'd0, 6'd4,  1'b0, 1'b1, 8'hFF, 1'b1},
        {2'd0, 6'd5,  1'b0, 1'b1, 8'hFF, 1'b1},
        {2'd0, 6'd6,  1'b0, 1'b1, 8'hFF, 1'b1},
        {2'd0, 6'd7,  1'b0, 1'b1, 8'hFF, 1'b1},
        {2'd0, 6'd9,  1'b0, 1'b1, 8'hFF, 1'b1},
        {2'd0, 6'd9,  1'b1, 1'b0, 8'hFE, 1'b1},
        {2'd0, 6'd9,  1'b1, 1'b0, 8'h7F, 1'b1},
        {2'd0, 6'd9,  1'b1, 1'b1, 8'h00, 1'b1},
        {2'd1, 6'd9,  1'b0, 1'b1, 8'hFF, 1'b1},
        {2'd0, 6'd12, 1'b0, 1'b0, 8'hAA, 1'b1},
        {2'd1, 6'd12, 1'b1, 1'b1, 8'hFF, 1'b1},
        {2'd2, 6'd5,  1'b1, 1'b1, 8'hFF, 1'b1},
        {2'd2, 6'd6,  1'b1, 1'b1, 8'hFF, 1'b0},
        {2'd2, 6'd5,  1'b1, 1'b1, 8'hFF, 1'b0},
        {2'd2, 6'd7,  1'b1, 1'b1, 8'hFF, 1'b1},
        {2'd1, 6'd3,  1'b1, 1'b1, 8'hFF, 1'b1},
        {2'd1, 6'd0,  1'b1, 1'b1, 8'hFF, 1'b0}
    };

    function automatic logic [63:0] pat(input int k);
        return (64'h9E3779B97F4A7C15 * 64'(k + 1)) ^ 64'(k);
    endfunction

    function automatic logic [63:0] merge(input logic [63:0] o, input logic [63:0] n,
                                          input logic g, input logic be, input logic [7:0] bw);
        logic [63:0] r;
        r = o;
        for (int l = 0; l < 8; l++)
            if (!g || (!be && !bw[l])) r[8*l +: 8] = n[8*l +: 8];
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        proc_strb_n = 1'b1; ctl_strb_n = 1'b1; burst_adv_n = 1'b1;
        all_wr_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = 8'hFF;
        sel_main_n = 1'b0; sel_aux = 1'b1; sel_aux_n = 1'b0;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_proc(input logic [5:0] a, input string req);
        idle(); proc_strb_n = 1'b0; addr = a;
        tick();
        chk(req, 64'(rdata_vld), 64'd1);
        chk(req, rdata, mdl[a]);
        idle();
    endtask

    task automatic wr_ctl(input logic [5:0] a, input logic [63:0] d, input logic g,
                          input logic be, input logic [7:0] bw);
        idle(); ctl_strb_n = 1'b0; addr = a; wdata = d;
        all_wr_n = g; lane_wr_en_n = be; lane_sel_n = bw;
        tick();
        mdl[a] = merge(mdl[a], d, g, be, bw);
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [18:0] v;
        logic [1:0]  op;
        logic [5:0]  a;
        logic [5:0]  ea;
        logic        g, be, ln, wr;
        logic [7:0]  bw;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", 64'(rdata_vld), 64'd0);
        chk("R1", rdata, 64'd0);
        chk("R1", {62'd0, pwr_down, wake_viol}, 64'd0);
        tick();
        chk("R1", 64'(rdata_vld), 64'd0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            v  = VEC[i];
            op = v[18:17]; a = v[16:11]; g = v[10]; be = v[9]; bw = v[8:1]; ln = v[0];
            linear_mode = ln;
            idle();
            case (op)
                2'd0: begin
                    ctl_strb_n = 1'b0; addr = a; wdata = pat(i);
                    all_wr_n = g; lane_wr_en_n = be; lane_sel_n = bw;
                    wr = !g || (!be && bw != 8'hFF);
                    tick();
                    if (wr) begin
                        mdl[a] = merge(mdl[a], pat(i), g, be, bw);
                        chk("R3", 64'(rdata_vld), 64'd0);
                    end else begin
                        chk("R3", 64'(rdata_vld), 64'd1);
                        chk("R4", rdata, mdl[a]);
                    end
                end
                2'd1: begin
                    proc_strb_n = 1'b0; addr = a; all_wr_n = g; wdata = ~pat(i);
                    tick();
                    chk("R2", 64'(rdata_vld), 64'd1);
                    chk("R2", rdata, mdl[a]);
                end
                default: begin
                    proc_strb_n = 1'b0; addr = a;
                    tick();
                    chk("R9", rdata, mdl[a]);
                    idle(); burst_adv_n = 1'b0;
                    for (int c = 1; c < 4; c++) begin
                        tick();
                        ea = {a[5:2], ln ? 2'(a[1:0] + 2'(c)) : (a[1:0] ^ 2'(c))};
                        chk("R9", 64'(rdata_vld), 64'd1);
                        chk("R9", rdata, mdl[ea]);
                    end
                end
            endcase
            idle();
        end
        linear_mode = 1'b1;

        // R4: single lane write keeps the other lanes
        wr_ctl(6'd30, 64'h1111_2222_3333_4444, 1'b0, 1'b1, 8'hFF);
        wr_ctl(6'd30, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 8'hF7);
        rd_proc(6'd30, "R4");
        chk("R4", mdl[30], 64'h1111_2222_FF33_4444);

        // R5: global write ignores the lane controls
        wr_ctl(6'd31, 64'hDEAD_BEEF_0BAD_F00D, 1'b0, 1'b1, 8'h5A);
        rd_proc(6'd31, "R5");

        // R10: asynchronous output enable
        rd_proc(6'd4, "R10");
        out_en_n = 1'b1; #1;
        chk("R10", 64'(rdata_vld), 64'd0);
        chk("R10", rdata, 64'd0);
        out_en_n = 1'b0; #1;
        chk("R10", rdata, mdl[4]);
        @(negedge clk);

        // R7: processor strobe blocked by the primary select
        rd_proc(6'd4, "R7");
        sel_main_n = 1'b1; proc_strb_n = 1'b0; addr = 6'd9;
        tick();
        chk("R7", rdata, mdl[4]);
        idle();

        // R8: secondary selects changed between strobes are ignored
        rd_proc(6'd4, "R8");
        sel_aux = 1'b0; sel_aux_n = 1'b1; burst_adv_n = 1'b0;
        tick();
        chk("R8", rdata, mdl[5]);
        idle();

        // R8: inactive secondary select on a strobe deselects
        ctl_strb_n = 1'b0; sel_aux = 1'b0; addr = 6'd9;
        tick();
        chk("R8", 64'(rdata_vld), 64'd0);
        idle(); all_wr_n = 1'b0; burst_adv_n = 1'b0; wdata = 64'hBAD0_BAD0_BAD0_BAD0;
        tick();
        chk("R8", 64'(rdata_vld), 64'd0);
        idle();
        rd_proc(6'd9, "R8");

        // R9: wait state repeats the address
        rd_proc(6'd4, "R9");
        tick();
        chk("R9", rdata, mdl[4]);
        burst_adv_n = 1'b0;
        tick();
        chk("R9", rdata, mdl[5]);
        idle();

        // R6: write after a processor-strobe read
        wr_ctl(6'd20, pat(200), 1'b0, 1'b1, 8'hFF);
        idle(); proc_strb_n = 1'b0; addr = 6'd20;
        tick();
        idle(); all_wr_n = 1'b0; wdata = pat(201);
        tick();
        chk("R6", 64'(rdata_vld), 64'd0);
        mdl[20] = pat(201);
        idle();
        rd_proc(6'd20, "R6");

        // R11: power-down keeps contents and refuses access
        sleep_req = 1'b1;
        tick();
        chk("R11", 64'(pwr_down), 64'd1);
        chk("R11", 64'(rdata_vld), 64'd0);
        ctl_strb_n = 1'b0; all_wr_n = 1'b0; addr = 6'd4; wdata = 64'hBADB_ADBA_DBAD_BADB;
        tick();
        chk("R11", 64'(rdata_vld), 64'd0);
        idle();

        // R12: recovery window
        sleep_req = 1'b0;
        tick();
        chk("R12", 64'(pwr_down), 64'd0);
        ctl_strb_n = 1'b0; all_wr_n = 1'b0; addr = 6'd4; wdata = 64'hBADB_ADBA_DBAD_BADB;
        tick();
        chk("R12", 64'(wake_viol), 64'd1);
        chk("R12", 64'(rdata_vld), 64'd0);
        tick();
        chk("R12", 64'(wake_viol), 64'd1);
        idle();
        rd_proc(6'd4, "R11");
        chk("R12", 64'(wake_viol), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule